// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block sits on the address bus of a 16-bit CPU. It decides which on-chip resource answers each bus access, and it widens the logical address into a 20-bit physical address. It can choose among five resources: a control-register block, an SRAM, an EEPROM, a flash array and the external bus. The logical range 0x8000 to 0xBFFF is a 16 KB paging window. A 6-bit page register picks which 16 KB page of the 1 MB physical space the window shows.

The register block, the SRAM and the EEPROM can be relocated. Software moves each one by writing its base register through a small configuration write port, and the same port loads the page register. Relocated resources may overlap each other or the flash. When they do, a fixed precedence decides the winner: the register block first, then SRAM, then EEPROM, then flash. The external bus takes any access that no on-chip resource claims.

The decision is registered. The resource select, the physical address and the read/write flag for an access appear one clock after the strobe. The physical address depends only on the logical address and the page register, whichever resource wins.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset, the page register is 0x00, the register-block base is 0x0000, the SRAM base is 0x3000 and the EEPROM base is 0x0000, and `valid_o` and `sel_o` are all zero.
- R2: For a logical address with bits [15:14] equal to 2'b10 (the window 0x8000 to 0xBFFF), `phys_o` is {page, addr[13:0]}.
- R3: Outside the window, 0x4000 to 0x7FFF maps to {0x3E, addr[13:0]}, 0xC000 to 0xFFFF maps to {0x3F, addr[13:0]}, and 0x0000 to 0x3FFF maps to the address zero-extended to 20 bits.
- R4: The register block covers 1 KB and is hit when addr[15:10] equals its base bits [15:10].
- R5: The SRAM and the EEPROM each cover 4 KB and are hit when addr[15:12] equals their base bits [15:12].
- R6: Overlaps are resolved with the register block first, then SRAM, then EEPROM, then flash, then external. `sel_o` bit 0 is the register block, bit 1 SRAM, bit 2 EEPROM, bit 3 flash and bit 4 external.
- R7: Every strobed access asserts exactly one select bit. Flash claims every address from 0x4000 upward, and external claims whatever no on-chip resource matches. With no strobe, `sel_o` is all zero.
- R8: A write with `cfg_we` high and `cfg_sel` set to 0 loads `cfg_wdata[5:0]` into the page register. `cfg_sel` values 1, 2 and 3 load the base registers of the register block, the SRAM and the EEPROM. Data bits beneath a resource's size alignment and the upper page bits are discarded. An access in the same cycle as a write decodes with the old value, and later accesses use the new one.
- R9: An access strobed in cycle t shows `valid_o` high, its decode and `rw_o` equal to its `cpu_rw` in cycle t+1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Logical address of the access |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strb | input | 1 | Access valid this cycle |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | 0 page, 1 register-block base, 2 SRAM base, 3 EEPROM base |
| cfg_wdata | input | 16 | Configuration write data |
| sel_o | output | 5 | One-hot resource select, registered |
| phys_o | output | 20 | Physical address, registered |
| valid_o | output | 1 | Decode of a strobed access is present |
| rw_o | output | 1 | Read/write flag of that access |

## Verification
A wrong page or base register stays hidden until an access lands in the region it governs. It then shows one cycle after the strobe, either as wrong upper bits of `phys_o` or as a select on the wrong resource. The bench therefore aims accesses at the edges of each relocated region and at every kind of overlap. It puts an access in the same cycle as a configuration write, so that a register updating one cycle too early or too late shows at once as a mismatched select.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    localparam int ADDR_W    = 16;
    localparam int PAGE_W    = 6;
    localparam int WIN_W     = 14;
    localparam int PHYS_W    = PAGE_W + WIN_W;
    localparam int TAG_W     = ADDR_W - WIN_W;
    localparam int NREL      = 3;
    localparam int NRES      = 5;
    localparam int CFG_SEL_W = 2;

    localparam int RES_REG   = 0;
    localparam int RES_RAM   = 1;
    localparam int RES_EE    = 2;
    localparam int RES_FLASH = 3;
    localparam int RES_EXT   = 4;

    localparam logic [TAG_W-1:0]  TAG_LOW  = 2'b00;
    localparam logic [TAG_W-1:0]  TAG_FIXL = 2'b01;
    localparam logic [TAG_W-1:0]  TAG_WIN  = 2'b10;
    localparam logic [TAG_W-1:0]  TAG_FIXH = 2'b11;
    localparam logic [PAGE_W-1:0] PAGE_RST = 6'h00;
    localparam logic [PAGE_W-1:0] FIX_LO   = 6'h3E;
    localparam logic [PAGE_W-1:0] FIX_HI   = 6'h3F;

    typedef struct packed {
        logic [PAGE_W-1:0]                page;
        logic [NREL-1:0][ADDR_W-1:0]      base;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic              rw;
        logic [NRES-1:0]   sel;
        logic [PHYS_W-1:0] phys;
    } out_t;

    // size of relocatable resource i as log2 of bytes
    function automatic int rel_log2(input int i);
        return (i == RES_REG) ? 10 : 12;
    endfunction

    function automatic logic [ADDR_W-1:0] rel_reset(input int i);
        return (i == RES_RAM) ? 16'h3000 : 16'h0000;
    endfunction

    function automatic logic [ADDR_W-1:0] align_mask(input int i);
        logic [ADDR_W-1:0] one;
        one = 1;
        return ~((one << rel_log2(i)) - one);
    endfunction

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.page = PAGE_RST;
        for (int i = 0; i < NREL; i++) c.base[i] = rel_reset(i);
        return c;
    endfunction
endpackage

// File: rtl/mmd_cfg_regs.sv
module mmd_cfg_regs
    import mmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_SEL_W-1:0] wsel,
    input  logic [ADDR_W-1:0]    wdata,
    output cfg_t                 cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (wsel == '0) begin
                cfg_d.page = wdata[PAGE_W-1:0];
            end else begin
                for (int i = 0; i < NREL; i++) begin
                    if (int'(wsel) == i + 1) cfg_d.base[i] = wdata & align_mask(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_reset();
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    a_r8_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsel == '0) |=> (cfg_q.page == $past(wdata[PAGE_W-1:0])));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/mmd_win_match.sv
module mmd_win_match #(
    parameter int ADDR_W    = 16,
    parameter int SIZE_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam int TOP_W = ADDR_W - SIZE_LOG2;
    logic [TOP_W-1:0] a_top, b_top;

    always_comb begin
        a_top = addr[ADDR_W-1:SIZE_LOG2];
        b_top = base[ADDR_W-1:SIZE_LOG2];
        hit   = (a_top == b_top);
    end
endmodule

// File: rtl/mmd_xlate.sv
module mmd_xlate
    import mmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic [PHYS_W-1:0] phys
);
    logic [TAG_W-1:0] tag;

    always_comb begin
        tag = addr[ADDR_W-1:WIN_W];
        unique case (tag)
            TAG_WIN:  phys = {page,   addr[WIN_W-1:0]};
            TAG_FIXL: phys = {FIX_LO, addr[WIN_W-1:0]};
            TAG_FIXH: phys = {FIX_HI, addr[WIN_W-1:0]};
            default:  phys = {{(PHYS_W-ADDR_W){1'b0}}, addr};
        endcase
    end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    input  logic        cpu_strb,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [4:0]  sel_o,
    output logic [19:0] phys_o,
    output logic        valid_o,
    output logic        rw_o
);
    cfg_t              cfg;
    logic [NRES-1:0]   hit;
    logic [NRES-1:0]   pick;
    logic [PHYS_W-1:0] phys_c;
    out_t              out_d, out_q;

    mmd_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NREL; g++) begin : g_rel
        mmd_win_match #(.ADDR_W(ADDR_W), .SIZE_LOG2(rel_log2(g))) u_match (
            .addr (cpu_addr),
            .base (cfg.base[g]),
            .hit  (hit[g])
        );
    end

    assign hit[RES_FLASH] = (cpu_addr[ADDR_W-1:WIN_W] != TAG_LOW);
    assign hit[RES_EXT]   = 1'b1;

    mmd_xlate u_xlate (
        .addr (cpu_addr),
        .page (cfg.page),
        .phys (phys_c)
    );

    // fixed precedence: lowest index wins
    always_comb begin
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NRES; i++) begin
            if (hit[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        out_d       = '0;
        out_d.valid = cpu_strb;
        if (cpu_strb) begin
            out_d.rw   = cpu_rw;
            out_d.sel  = pick;
            out_d.phys = phys_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sel_o   = out_q.sel;
    assign phys_o  = out_q.phys;
    assign valid_o = out_q.valid;
    assign rw_o    = out_q.rw;

    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_strb |=> (valid_o && rw_o == $past(cpu_rw)));
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strb |=> (!valid_o && sel_o == '0));
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $onehot(sel_o));
    a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb && cpu_addr[15:14] == TAG_WIN)
        |=> (phys_o[PHYS_W-1:WIN_W] == $past(cfg.page)));
    a_r6_reg_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb && hit[RES_REG]) |=> sel_o[RES_REG]);
    a_r6_ram_over_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strb && hit[RES_RAM] && !hit[RES_REG]) |=> sel_o[RES_RAM]);
endmodule

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_strb = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [4:0]  sel_o;
    logic [19:0] phys_o;
    logic        valid_o;
    logic        rw_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0]  q_sel[$];
    logic [19:0] q_phys[$];
    logic        q_rw[$];
    string       q_tag[$];

    // bench-side copy of the configuration, per the requirements
    logic [5:0]  m_page = 6'h00;
    logic [15:0] m_reg  = 16'h0000;
    logic [15:0] m_ram  = 16'h3000;
    logic [15:0] m_ee   = 16'h0000;

    mem_map_decoder uut (.*);

    always #5 clk = ~clk;

    function automatic logic [4:0] exp_sel(input logic [15:0] a);
        if (a[15:10] == m_reg[15:10]) return 5'b00001;
        if (a[15:12] == m_ram[15:12]) return 5'b00010;
        if (a[15:12] == m_ee[15:12])  return 5'b00100;
        if (a >= 16'h4000)            return 5'b01000;
        return 5'b10000;
    endfunction

    function automatic logic [19:0] exp_phys(input logic [15:0] a);
        case (a[15:14])
            2'b10:   return {m_page, a[13:0]};
            2'b01:   return {6'h3E, a[13:0]};
            2'b11:   return {6'h3F, a[13:0]};
            default: return {4'h0, a};
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // one bus cycle: optional access and optional configuration write
    task automatic cycle(input bit strb, input logic [15:0] a, input bit rw,
                         input bit we, input logic [1:0] cs, input logic [15:0] wd,
                         input string tag);
        @(negedge clk);
        cpu_strb = strb; cpu_addr = a; cpu_rw = rw;
        cfg_we = we; cfg_sel = cs; cfg_wdata = wd;
        if (strb) begin
            q_sel.push_back(exp_sel(a));
            q_phys.push_back(exp_phys(a));
            q_rw.push_back(rw);
            q_tag.push_back(tag);
        end
        if (we) begin
            case (cs)
                2'd0: m_page = wd[5:0];
                2'd1: m_reg  = {wd[15:10], 10'h0};
                2'd2: m_ram  = {wd[15:12], 12'h0};
                default: m_ee = {wd[15:12], 12'h0};
            endcase
        end
    endtask

    task automatic access(input logic [15:0] a, input bit rw, input string tag);
        cycle(1'b1, a, rw, 1'b0, 2'd0, 16'h0, tag);
    endtask

    task automatic cfg_write(input logic [1:0] cs, input logic [15:0] wd);
        cycle(1'b0, 16'h0, 1'b1, 1'b1, cs, wd, "");
    endtask

    task automatic idle();
        cycle(1'b0, 16'h0, 1'b1, 1'b0, 2'd0, 16'h0, "");
    endtask

    // monitor: compares each registered decode against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                if (valid_o) begin
                    if (q_sel.size() == 0) begin
                        check(1'b0, "R9", "valid_o with no access pending");
                    end else begin
                        logic [4:0]  es;
                        logic [19:0] ep;
                        logic        er;
                        string       t;
                        es = q_sel.pop_front();
                        ep = q_phys.pop_front();
                        er = q_rw.pop_front();
                        t  = q_tag.pop_front();
                        check(sel_o == es && phys_o == ep && rw_o == er, t,
                              $sformatf("sel=%b phys=%h rw=%b expected sel=%b phys=%h rw=%b",
                                        sel_o, phys_o, rw_o, es, ep, er));
                    end
                end else if (q_sel.size() == 0) begin
                    check(sel_o == 5'b0, "R7", $sformatf("idle sel=%b expected 00000", sel_o));
                end else begin
                    check(1'b0, "R9", "access pending but valid_o low");
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        check(valid_o == 1'b0 && sel_o == 5'b0, "R1",
              $sformatf("valid=%b sel=%b expected 0/00000", valid_o, sel_o));
        @(negedge clk);
        rst_n = 1'b1;

        // R1 defaults, R4 R6: register block over EEPROM at 0x0000
        access(16'h0010, 1'b1, "R1_R6_reg_default");
        access(16'h03FF, 1'b0, "R4_reg_top");
        access(16'h0400, 1'b1, "R5_ee_default");
        access(16'h3004, 1'b1, "R5_ram_default");
        access(16'h2000, 1'b0, "R7_ext_default");
        access(16'h8123, 1'b1, "R2_window_page0");
        access(16'h5000, 1'b1, "R3_fixed_low");
        access(16'hC010, 1'b0, "R3_fixed_high");
        access(16'h3FFF, 1'b1, "R3_zero_extend");
        idle();

        // R8: page write, upper data bits dropped
        cfg_write(2'd0, 16'hFFD5);
        access(16'hBFFF, 1'b1, "R2_R8_page_15");
        access(16'h8000, 1'b0, "R2_window_bottom");

        // R4: relocate register block, low bits dropped
        cfg_write(2'd1, 16'h83FF);
        access(16'h8000, 1'b1, "R4_reg_reloc_base");
        access(16'h83FF, 1'b1, "R4_reg_reloc_top");
        access(16'h8400, 1'b1, "R4_reg_reloc_past");
        access(16'h0010, 1'b1, "R8_old_reg_gone");

        // R6: SRAM overlapping register block
        cfg_write(2'd2, 16'h8ABC);
        access(16'h8010, 1'b1, "R6_reg_over_ram");
        access(16'h8800, 1'b0, "R6_ram_over_flash");

        // R5 R6: EEPROM under SRAM, then alone
        cfg_write(2'd3, 16'h8000);
        access(16'h8900, 1'b1, "R6_ram_over_ee");
        cfg_write(2'd3, 16'h9FFF);
        access(16'h9ABC, 1'b1, "R5_ee_reloc");
        access(16'hA000, 1'b1, "R5_ee_past_top");

        // R8: access in same cycle as write uses old base
        cycle(1'b1, 16'h2010, 1'b1, 1'b1, 2'd2, 16'h2000, "R8_same_cycle_old");
        access(16'h2010, 1'b0, "R8_next_cycle_new");
        // R8: page write with concurrent window access
        cycle(1'b1, 16'h8004, 1'b1, 1'b1, 2'd0, 16'h002A, "R8_page_same_cycle");
        access(16'h8004, 1'b1, "R8_page_next_cycle");
        idle();
        idle();

        // R1 R8: reset restores defaults
        rst_n = 1'b0;
        m_page = 6'h00; m_reg = 16'h0000; m_ram = 16'h3000; m_ee = 16'h0000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(16'h3010, 1'b1, "R1_ram_default_after_reset");
        access(16'h8001, 1'b1, "R1_page_default_after_reset");
        idle();
        idle();

        check(q_sel.size() == 0, "R9",
              $sformatf("pending=%0d expected 0", q_sel.size()));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule